// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit sits beside the command decoder of a serial memory slave and owns the one-byte status register. It decides whether a byte may be written into the memory array and whether the status register itself may be rewritten. The decoder reports single-cycle events to it: set or clear the write-enable latch, a status write with its data byte, the end of a memory write operation, and the start of a new chip-select frame. It also reports the address of the byte about to be written. The unit answers with the status byte for readback and with two permission levels.

Protection works in layers. The write-enable latch must be set before any write, and it drops by itself once a write has been carried out. A two-bit block code marks an upper part of the address space as read-only. A lock bit lets the active-low hardware protect pin freeze the status register. The pin is sampled once per frame, at the frame start. The lock bit and the block code are plain flops with parameterised reset values.

Top module: `sr_guard`

## Requirements
- R1: The status byte is {lock, 1, 0, 0, blk[1:0], wel, 0}, with lock at bit 7, the block code at bits 3:2 and the write-enable latch at bit 1. After reset it reads 8'h40 with the default parameters. Bits 6, 5, 4 and 0 keep their fixed values whatever data a status write carries.
- R2: A set-enable event makes wel read 1 from the next cycle on.
- R3: A clear-enable event makes wel read 0 from the next cycle on.
- R4: wel reads 0 in the cycle after a write-done event, and also in the cycle after an accepted status write.
- R5: When wel=1, mem_wr_ok is 0 for addresses inside the protected range and 1 outside it. The protected range depends on the block code. Code 00 protects nothing. Code 01 protects addresses whose top two bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R6: When wel=0, mem_wr_ok and sr_wr_ok are both 0, and a status write leaves the status byte unchanged.
- R7: With lock=1, sr_wr_ok is 0 while the captured pin level is low. With lock=0, the pin level has no effect on sr_wr_ok.
- R8: The pin level counts only as sampled on a frame-start event. A pin change between frame starts leaves sr_wr_ok unchanged until the next frame start. The captured level resets to low.
- R9: A status write that is refused leaves every status bit unchanged, wel included.
- R10: When a set-enable event arrives in the same cycle as a clear-enable or write-done event, the clear wins and wel reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| frame_start | input | 1 | One-cycle pulse at a chip-select falling edge; captures wp_n |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| ev_wen_set | input | 1 | Set the write-enable latch |
| ev_wen_clr | input | 1 | Clear the write-enable latch |
| ev_sr_wr | input | 1 | Status write request, data on sr_wdata |
| sr_wdata | input | 8 | Status write data: bit 7 lock, bits 3:2 block code, other bits ignored |
| ev_wr_done | input | 1 | A memory write operation has completed |
| chk_addr | input | ADDR_W | Byte address to be judged for memory write permission |
| status_byte | output | 8 | Status register readback |
| mem_wr_ok | output | 1 | Memory write allowed at chk_addr |
| sr_wr_ok | output | 1 | Status register write allowed |

## Verification
The hardest state to reach from the ports is a status register that is locked by the pin while wel is still set. A refused write can only be told apart from an accepted one in that state, because wel would otherwise already have dropped. To get there, the stimulus first programs lock=1 during a frame in which the pin was sampled high. It then sets wel again and drops the pin without a frame start, which shows that the status register stays writable. Only after that does it start a new frame with the pin low and issue a status write, which must leave all eight bits unchanged. Memory permissions are swept over every address of a six-bit configuration, for all four block codes and both wel states.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  typedef enum logic [1:0] {
    BLK_NONE    = 2'b00,
    BLK_QUARTER = 2'b01,
    BLK_HALF    = 2'b10,
    BLK_ALL     = 2'b11
  } blk_code_e;

  localparam int SR_W        = 8;
  localparam int SR_LOCK_POS = 7;
  localparam int SR_ONE_POS  = 6;
  localparam int SR_BLK_HI   = 3;
  localparam int SR_BLK_LO   = 2;
  localparam int SR_WEL_POS  = 1;

  function automatic logic [SR_W-1:0] pack_status(logic lock, blk_code_e blk, logic wel);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_LOCK_POS]         = lock;
    s[SR_ONE_POS]          = 1'b1;
    s[SR_BLK_HI:SR_BLK_LO] = blk;
    s[SR_WEL_POS]          = wel;
    return s;
  endfunction

endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  logic wel_q, wel_d, wel_en;

  always_comb begin
    wel_en = set_i | clr_i;
    wel_d  = wel_q;
    if (clr_i)      wel_d = 1'b0;
    else if (set_i) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel_o = wel_q;

endmodule

// File: rtl/sr_fields.sv
module sr_fields
  import sr_guard_pkg::*;
#(
  parameter logic      RST_LOCK = 1'b0,
  parameter blk_code_e RST_BLK  = BLK_NONE
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start_i,
  input  logic      wp_n_i,
  input  logic      wel_i,
  input  logic      wr_i,
  input  logic      lock_d_i,
  input  logic [1:0] blk_d_i,
  output logic      lock_o,
  output blk_code_e blk_o,
  output logic      sr_ok_o,
  output logic      accept_o
);

  logic      pin_q, pin_d, pin_en;
  logic      lock_q, lock_d;
  blk_code_e blk_q, blk_d;
  logic      fld_en;

  // pin sample: taken once per frame, held for the rest of it
  always_comb begin
    pin_en = frame_start_i;
    pin_d  = wp_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  // permission and field update
  always_comb begin
    sr_ok_o  = wel_i & ~(lock_q & ~pin_q);
    accept_o = wr_i & sr_ok_o;
    fld_en   = accept_o;
    lock_d   = lock_d_i;
    blk_d    = blk_code_e'(blk_d_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= RST_LOCK;
      blk_q  <= RST_BLK;
    end else if (fld_en) begin
      lock_q <= lock_d;
      blk_q  <= blk_d;
    end
  end

  assign lock_o = lock_q;
  assign blk_o  = blk_q;

endmodule

// File: rtl/sr_range_guard.sv
module sr_range_guard
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  blk_code_e         blk_i,
  input  logic              wel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o
);

  logic in_quarter, in_half, hit;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_quarter = &addr_i[ADDR_W-1:ADDR_W-2];
    end else begin : g_narrow
      assign in_quarter = addr_i[ADDR_W-1];
    end
  endgenerate

  assign in_half = addr_i[ADDR_W-1];

  always_comb begin
    unique case (blk_i)
      BLK_NONE:    hit = 1'b0;
      BLK_QUARTER: hit = in_quarter;
      BLK_HALF:    hit = in_half;
      BLK_ALL:     hit = 1'b1;
      default:     hit = 1'b1;
    endcase
    ok_o = wel_i & ~hit;
  end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int        ADDR_W   = 18,
  parameter logic      RST_LOCK = 1'b0,
  parameter blk_code_e RST_BLK  = BLK_NONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              wp_n,
  input  logic              ev_wen_set,
  input  logic              ev_wen_clr,
  input  logic              ev_sr_wr,
  input  logic [7:0]        sr_wdata,
  input  logic              ev_wr_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok
);

  logic      wel, lock, sr_accept, wel_clr;
  blk_code_e blk;
  logic      unused_wdata;

  assign unused_wdata = ^{sr_wdata[6:4], sr_wdata[1:0]};

  assign wel_clr = ev_wen_clr | ev_wr_done | sr_accept;

  sr_wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_wen_set),
    .clr_i (wel_clr),
    .wel_o (wel)
  );

  sr_fields #(
    .RST_LOCK (RST_LOCK),
    .RST_BLK  (RST_BLK)
  ) u_fields (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .wp_n_i        (wp_n),
    .wel_i         (wel),
    .wr_i          (ev_sr_wr),
    .lock_d_i      (sr_wdata[SR_LOCK_POS]),
    .blk_d_i       (sr_wdata[SR_BLK_HI:SR_BLK_LO]),
    .lock_o        (lock),
    .blk_o         (blk),
    .sr_ok_o       (sr_wr_ok),
    .accept_o      (sr_accept)
  );

  sr_range_guard #(.ADDR_W(ADDR_W)) u_range (
    .blk_i  (blk),
    .wel_i  (wel),
    .addr_i (chk_addr),
    .ok_o   (mem_wr_ok)
  );

  assign status_byte = pack_status(lock, blk, wel);

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       wp_n,
  input logic       ev_wen_set,
  input logic       ev_wen_clr,
  input logic       ev_sr_wr,
  input logic       ev_wr_done,
  input logic [7:0] status_byte,
  input logic       mem_wr_ok,
  input logic       sr_wr_ok
);

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wen_set && !ev_wen_clr && !ev_wr_done && !ev_sr_wr) |=> status_byte[1]);

  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wen_clr |=> !status_byte[1]);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_done |=> !status_byte[1]);

  assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);

  assert_no_wel_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[1] |-> (!mem_wr_ok && !sr_wr_ok));

  assert_pin_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !wp_n) |=> (status_byte[7] -> !sr_wr_ok));

  assert_refused_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_wr && !sr_wr_ok && !ev_wen_set && !ev_wen_clr && !ev_wr_done)
      |=> $stable(status_byte));

endmodule

bind sr_guard sr_guard_chk u_sr_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .wp_n        (wp_n),
  .ev_wen_set  (ev_wen_set),
  .ev_wen_clr  (ev_wen_clr),
  .ev_sr_wr    (ev_sr_wr),
  .ev_wr_done  (ev_wr_done),
  .status_byte (status_byte),
  .mem_wr_ok   (mem_wr_ok),
  .sr_wr_ok    (sr_wr_ok)
);

// File: tb/test_sr_guard.sv
`timescale 1ns/1ps
module test_sr_guard;

  localparam int AW = 6;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start, wp_n, ev_wen_set, ev_wen_clr, ev_sr_wr, ev_wr_done;
  logic [7:0]    sr_wdata;
  logic [AW-1:0] chk_addr;
  logic [7:0]    status_byte;
  logic          mem_wr_ok, sr_wr_ok;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  // bench model
  logic       m_wel, m_lock, m_pin;
  logic [1:0] m_blk;

  always #2.5 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) i_sr_guard (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wp_n(wp_n),
    .ev_wen_set(ev_wen_set), .ev_wen_clr(ev_wen_clr), .ev_sr_wr(ev_sr_wr),
    .sr_wdata(sr_wdata), .ev_wr_done(ev_wr_done), .chk_addr(chk_addr),
    .status_byte(status_byte), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
  );

  function automatic logic [7:0] exp_status();
    return {m_lock, 1'b1, 2'b00, m_blk, m_wel, 1'b0};
  endfunction

  function automatic bit prot(logic [1:0] b, int a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a >= 3 * (NA / 4);
      2'b10:   return a >= NA / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    frame_start = 0; ev_wen_set = 0; ev_wen_clr = 0; ev_sr_wr = 0; ev_wr_done = 0;
    #1;
  endtask

  task automatic frame(logic pin);
    @(negedge clk); wp_n = pin; frame_start = 1; m_pin = pin; step();
  endtask

  task automatic wren();
    @(negedge clk); ev_wen_set = 1; m_wel = 1; step();
  endtask

  task automatic wrdi();
    @(negedge clk); ev_wen_clr = 1; m_wel = 0; step();
  endtask

  task automatic srwr(logic [7:0] d);
    bit ok;
    ok = m_wel && !(m_lock && !m_pin);
    @(negedge clk); ev_sr_wr = 1; sr_wdata = d;
    if (ok) begin m_lock = d[7]; m_blk = d[3:2]; m_wel = 0; end
    step();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; frame_start = 0; wp_n = 1; ev_wen_set = 0; ev_wen_clr = 0;
    ev_sr_wr = 0; ev_wr_done = 0; sr_wdata = 0; chk_addr = 0;
    m_wel = 0; m_lock = 0; m_pin = 0; m_blk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;

    // R1 reset state; R8 captured pin resets low (irrelevant while lock=0)
    chk("R1 reset status", status_byte, 8'h40);
    chk("R6 reset sr_wr_ok", {7'd0, sr_wr_ok}, 8'd0);

    // R6 status write with wel=0 is ignored
    srwr(8'h8C);
    chk("R6 write without wel", status_byte, 8'h40);

    // R2 set, R3 clear
    wren(); chk("R2 wel set", status_byte, exp_status());
    wrdi(); chk("R3 wel clear", status_byte, exp_status());

    // R4 write-done clears wel
    wren();
    @(negedge clk); ev_wr_done = 1; m_wel = 0; step();
    chk("R4 write done clears wel", status_byte, exp_status());

    // R10 set with clear, set with done
    @(negedge clk); ev_wen_set = 1; ev_wen_clr = 1; step();
    chk("R10 set+clear", status_byte, 8'h40);
    @(negedge clk); ev_wen_set = 1; ev_wr_done = 1; step();
    chk("R10 set+done", status_byte, 8'h40);

    // R1 fixed bits ignore write data, R4 accepted status write clears wel
    frame(1'b1);
    wren(); srwr(8'h7F);
    chk("R1 fixed bits", status_byte, 8'h4C);
    chk("R4 status write clears wel", {7'd0, status_byte[1]}, 8'd0);

    // R5 / R6 sweep of all block codes and addresses
    for (int b = 0; b < 4; b++) begin
      wren(); srwr({6'b0, 2'(b)} << 2 | 8'h33);
      chk("R5 block code stored", status_byte, exp_status());
      wren();
      for (int a = 0; a < NA; a++) begin
        chk_addr = AW'(a); #1;
        chk("R5 mem_wr_ok", {7'd0, mem_wr_ok}, {7'd0, !prot(2'(b), a)});
      end
      wrdi();
      for (int a = 0; a < NA; a++) begin
        chk_addr = AW'(a); #1;
        chk("R6 mem_wr_ok wel=0", {7'd0, mem_wr_ok}, 8'd0);
      end
      chk("R6 sr_wr_ok wel=0", {7'd0, sr_wr_ok}, 8'd0);
    end

    // R7 / R8 / R9 pin lock
    wren(); srwr(8'h80);
    chk("R7 lock set", status_byte, 8'hC0);
    wren();
    @(negedge clk); wp_n = 0; #1;
    chk("R8 mid-frame pin change ignored", {7'd0, sr_wr_ok}, 8'd1);
    frame(1'b0);
    chk("R7 locked by pin", {7'd0, sr_wr_ok}, 8'd0);
    srwr(8'h0C);
    chk("R9 refused write keeps all bits", status_byte, 8'hC2);
    @(negedge clk); wp_n = 1; #1;
    chk("R8 pin release mid-frame ignored", {7'd0, sr_wr_ok}, 8'd0);
    frame(1'b1);
    chk("R8 release taken at frame start", {7'd0, sr_wr_ok}, 8'd1);
    srwr(8'h04);
    chk("R7 unlocked write", status_byte, 8'h44);
    frame(1'b0); wren();
    chk("R7 pin ignored when lock=0", {7'd0, sr_wr_ok}, 8'd1);
    srwr(8'h00);
    chk("R7 write with pin low and lock=0", status_byte, 8'h40);

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule